// File: doc/BRIEF.md
# 4B/5B Line Coder with NRZ-I Serial Link

This block is both ends of a narrow serial link. On the send side it accepts a 4-bit data nibble or a control-symbol request through a valid/ready handshake. It substitutes the matching 5-bit code group and shifts that group onto a single line, one bit per clock and most significant bit first. The line uses NRZ-I, so a 1 flips the line level and a 0 leaves it unchanged. When no request is waiting at a group boundary, the sender fills the gap with idle groups, so the line never goes quiet.

On the receive side the block recovers bits by comparing each sampled line level with the one before it. Because only changes in level carry information, swapping the two line wires does not alter the recovered stream. The receiver collects the last five bits in a shift register. An external strobe tells it which cycle holds the final bit of a group. For that group it reports a data nibble, one of three control symbols, or a flag that the group is not a legal code. Locating group boundaries and recovering the clock are left to the surrounding logic.

Top module: `fbfb_link`

## Requirements
- R1: With `tx_ctrl`=0, an accepted nibble is sent as this group (nibble hex→group): 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R2: With `tx_ctrl`=1, `tx_data[1:0]` selects a control group: 0 = idle 11111, 1 = dead line 00000, 2 = halt 00100, 3 = idle 11111. `tx_data[3:2]` has no effect on the group that is sent.
- R3: A group goes out most significant bit first, one bit per clock. At each rising edge `line_out` toggles if the current bit is 1 and holds if it is 0.
- R4: `tx_ready` is high for exactly one cycle in every five: the cycle whose closing edge sends the last bit of the current group. A request that is valid in that cycle is taken at that edge, and the first bit of its group is sent at the next edge.
- R5: If `tx_valid` is low while `tx_ready` is high, the next group sent is idle (11111).
- R6: After synchronous reset, `line_out` is 0 and the first group sent is idle. `tx_ready` first goes high in the fifth cycle after reset is released, and `rx_valid` is low.
- R7: At each rising edge the receiver recovers a bit that is 1 when `rx_line_in` differs from its level at the previous edge. The stored level resets to 0, the same value as `line_out`.
- R8: When `rx_align` is high at an edge, the group made of the four previously recovered bits (oldest first) followed by the bit recovered at that edge is decoded. `rx_valid` is high for the one cycle after that edge.
- R9: A decoded data group gives `rx_ctrl`=0, `rx_invalid`=0, and `rx_data` equal to the nibble listed in R1.
- R10: A decoded control group gives `rx_ctrl`=1, `rx_invalid`=0, and `rx_data` equal to 0 for 11111, 1 for 00000 and 2 for 00100.
- R11: Any other group gives `rx_invalid`=1, `rx_ctrl`=0 and `rx_data`=0.
- R12: Inverting the line between sender and receiver does not change the decoded symbols.
- R13: When `rx_valid` is low, `rx_ctrl`, `rx_data` and `rx_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | A symbol request is offered |
| tx_ctrl | input | 1 | 1: the request is a control symbol; 0: it is a data nibble |
| tx_data | input | 4 | Nibble, or control selector in bits [1:0] |
| tx_ready | output | 1 | The request is taken at this edge |
| line_out | output | 1 | NRZ-I line level |
| rx_line_in | input | 1 | Sampled line level |
| rx_align | input | 1 | The current sample carries the last bit of a group |
| rx_valid | output | 1 | A decoded group is presented |
| rx_ctrl | output | 1 | The decoded group is a control symbol |
| rx_data | output | 4 | Decoded nibble or control index |
| rx_invalid | output | 1 | The decoded group is not a legal code |

## Verification
In a loopback, the receiver only ever sees groups that the sender can produce. The thirteen illegal groups, the dead-line and halt symbols arriving back to back, and a polarity flip in the middle of a stream never appear on their own. To reach them, the bench first runs loopback traffic, then inverts the line, and finally detaches the receiver from the sender. In that last phase it drives all 32 possible groups directly as NRZ-I levels, with the alignment strobe placed on each fifth bit. The reference model follows the same level sequence through every phase, so the switch-over cycles are checked as well.

// File: rtl/fbfb_pkg.sv
package fbfb_pkg;
  localparam int NIB_W = 4;
  localparam int GRP_W = 5;
  localparam int IDX_W = $clog2(GRP_W);
  localparam int NUM_NIB = 1 << NIB_W;

  localparam logic [GRP_W-1:0] GRP_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] GRP_DEAD = 5'b00000;
  localparam logic [GRP_W-1:0] GRP_HALT = 5'b00100;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_DEAD  = 2'd1,
    CS_HALT  = 2'd2,
    CS_SPARE = 2'd3
  } ctl_sym_e;

  typedef enum logic [1:0] {
    GK_DATA = 2'd0,
    GK_CTRL = 2'd1,
    GK_BAD  = 2'd2
  } grp_kind_e;

  typedef struct packed {
    grp_kind_e        kind;
    logic [NIB_W-1:0] val;
  } grp_info_t;

  // nibble to code group substitution
  function automatic logic [GRP_W-1:0] enc_nibble(input logic [NIB_W-1:0] n);
    logic [GRP_W-1:0] g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

  function automatic logic [GRP_W-1:0] enc_ctrl(input logic [1:0] c);
    logic [GRP_W-1:0] g;
    case (ctl_sym_e'(c))
      CS_DEAD: g = GRP_DEAD;
      CS_HALT: g = GRP_HALT;
      default: g = GRP_IDLE;
    endcase
    return g;
  endfunction

  // reverse lookup: data, control or illegal
  function automatic grp_info_t classify(input logic [GRP_W-1:0] g);
    grp_info_t r;
    r.kind = GK_BAD;
    r.val  = '0;
    if (g == GRP_IDLE) begin
      r.kind = GK_CTRL;
      r.val  = NIB_W'(CS_IDLE);
    end else if (g == GRP_DEAD) begin
      r.kind = GK_CTRL;
      r.val  = NIB_W'(CS_DEAD);
    end else if (g == GRP_HALT) begin
      r.kind = GK_CTRL;
      r.val  = NIB_W'(CS_HALT);
    end else begin
      for (int i = 0; i < NUM_NIB; i++) begin
        if (enc_nibble(NIB_W'(i)) == g) begin
          r.kind = GK_DATA;
          r.val  = NIB_W'(i);
        end
      end
    end
    return r;
  endfunction

  // level after sending one bit
  function automatic logic nrzi_step(input logic level, input logic b);
    return level ^ b;
  endfunction

  // bit recovered from two successive levels
  function automatic logic nrzi_recover(input logic now_lvl, input logic prev_lvl);
    return now_lvl != prev_lvl;
  endfunction
endpackage

// File: rtl/fbfb_tx.sv
module fbfb_tx
  import fbfb_pkg::*;
#(
  parameter logic LINE_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic             tx_ctrl,
  input  logic [NIB_W-1:0] tx_data,
  output logic             tx_ready,
  output logic             line_out,
  output logic             cur_bit,
  output logic [GRP_W-1:0] cur_grp
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_W - 1);

  logic [IDX_W-1:0] idx_q;
  logic [GRP_W-1:0] shf_q;
  logic [GRP_W-1:0] grp_q;
  logic             line_q;
  logic             at_last;
  logic [GRP_W-1:0] next_grp;

  assign at_last  = (idx_q == LAST_IDX);
  assign tx_ready = at_last;
  assign cur_bit  = shf_q[GRP_W-1];
  assign cur_grp  = grp_q;
  assign line_out = line_q;

  always_comb begin
    if (!tx_valid)    next_grp = GRP_IDLE;
    else if (tx_ctrl) next_grp = enc_ctrl(tx_data[1:0]);
    else              next_grp = enc_nibble(tx_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      shf_q  <= GRP_IDLE;
      grp_q  <= GRP_IDLE;
      line_q <= LINE_RST;
    end else begin
      line_q <= nrzi_step(line_q, cur_bit);
      if (at_last) begin
        idx_q <= '0;
        shf_q <= next_grp;
        grp_q <= next_grp;
      end else begin
        idx_q <= idx_q + 1'b1;
        shf_q <= {shf_q[GRP_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/fbfb_rx_front.sv
module fbfb_rx_front
  import fbfb_pkg::*;
#(
  parameter logic LINE_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  output logic             rx_bit,
  output logic [GRP_W-1:0] grp_now
);
  logic             prev_q;
  logic [GRP_W-2:0] hist_q;

  assign rx_bit  = nrzi_recover(line_in, prev_q);
  assign grp_now = {hist_q, rx_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= LINE_RST;
      hist_q <= '0;
    end else begin
      prev_q <= line_in;
      hist_q <= grp_now[GRP_W-2:0];
    end
  end
endmodule

// File: rtl/fbfb_rx_dec.sv
module fbfb_rx_dec
  import fbfb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align,
  input  logic [GRP_W-1:0] grp,
  output logic             rx_valid,
  output logic             rx_ctrl,
  output logic [NIB_W-1:0] rx_data,
  output logic             rx_invalid
);
  grp_info_t info;

  assign info = classify(grp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_ctrl    <= 1'b0;
      rx_data    <= '0;
      rx_invalid <= 1'b0;
    end else begin
      rx_valid   <= align;
      rx_ctrl    <= align && (info.kind == GK_CTRL);
      rx_invalid <= align && (info.kind == GK_BAD);
      rx_data    <= (align && info.kind != GK_BAD) ? info.val : '0;
    end
  end
endmodule

// File: rtl/fbfb_link.sv
module fbfb_link
  import fbfb_pkg::*;
#(
  parameter logic LINE_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic       tx_ctrl,
  input  logic [3:0] tx_data,
  output logic       tx_ready,
  output logic       line_out,
  input  logic       rx_line_in,
  input  logic       rx_align,
  output logic       rx_valid,
  output logic       rx_ctrl,
  output logic [3:0] rx_data,
  output logic       rx_invalid
);
  // named internal events for the checker
  logic             tx_bit;
  logic [GRP_W-1:0] tx_grp;
  logic             rx_bit;
  logic [GRP_W-1:0] rx_grp;

  fbfb_tx #(.LINE_RST(LINE_RST)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ctrl  (tx_ctrl),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .line_out (line_out),
    .cur_bit  (tx_bit),
    .cur_grp  (tx_grp)
  );

  fbfb_rx_front #(.LINE_RST(LINE_RST)) u_rxf (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (rx_line_in),
    .rx_bit  (rx_bit),
    .grp_now (rx_grp)
  );

  fbfb_rx_dec u_rxd (
    .clk        (clk),
    .rst_n      (rst_n),
    .align      (rx_align),
    .grp        (rx_grp),
    .rx_valid   (rx_valid),
    .rx_ctrl    (rx_ctrl),
    .rx_data    (rx_data),
    .rx_invalid (rx_invalid)
  );
endmodule

// File: rtl/fbfb_link_checker.sv
module fbfb_link_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       line_out,
  input logic       tx_bit,
  input logic [4:0] tx_grp,
  input logic       rx_align,
  input logic       rx_valid,
  input logic       rx_ctrl,
  input logic [3:0] rx_data,
  input logic       rx_invalid
);
  a_r3_one_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit |=> (line_out != $past(line_out)));

  a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit |=> $stable(line_out));

  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  a_r5_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> (tx_grp == 5'b11111));

  a_r8_valid_after_align: assert property (@(posedge clk) disable iff (!rst_n)
    rx_align |=> rx_valid);

  a_r8_no_valid_without_align: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_align |=> !rx_valid);

  a_r11_invalid_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rx_invalid |-> (rx_valid && !rx_ctrl && rx_data == 4'd0));

  a_r13_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (!rx_ctrl && !rx_invalid && rx_data == 4'd0));
endmodule

bind fbfb_link fbfb_link_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .line_out   (line_out),
  .tx_bit     (tx_bit),
  .tx_grp     (tx_grp),
  .rx_align   (rx_align),
  .rx_valid   (rx_valid),
  .rx_ctrl    (rx_ctrl),
  .rx_data    (rx_data),
  .rx_invalid (rx_invalid)
);

// File: tb/fbfb_link_bench.sv
module fbfb_link_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0, tx_ctrl = 1'b0;
  logic [3:0] tx_data = '0;
  logic       tx_ready, line_out, rx_line_in, rx_align;
  logic       rx_valid, rx_ctrl, rx_invalid;
  logic [3:0] rx_data;

  logic inv = 1'b0, direct = 1'b0, drv_line = 1'b0;
  logic dir_align = 1'b0, loop_align;

  assign rx_line_in = direct ? drv_line : (line_out ^ inv);
  assign rx_align   = direct ? dir_align : loop_align;

  fbfb_link u_fbfb_link (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ctrl(tx_ctrl),
    .tx_data(tx_data), .tx_ready(tx_ready), .line_out(line_out),
    .rx_line_in(rx_line_in), .rx_align(rx_align), .rx_valid(rx_valid),
    .rx_ctrl(rx_ctrl), .rx_data(rx_data), .rx_invalid(rx_invalid)
  );

  // code table indexed by nibble
  localparam logic [4:0] CODES [16] = '{
    5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
    5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R6";
  bit checking = 1'b0;

  // reference model state
  int         m_idx;
  logic [4:0] m_grp;
  logic       m_line, m_prev, m_started;
  logic [3:0] m_hist;
  logic       e_valid, e_ctrl, e_inv;
  logic [3:0] e_data;

  function automatic logic [4:0] ref_code(input logic c, input logic [3:0] d);
    if (!c) return CODES[d];
    if (d[1:0] == 2'd1) return 5'b00000;
    if (d[1:0] == 2'd2) return 5'b00100;
    return 5'b11111;
  endfunction

  always @(posedge clk) begin
    logic lin, b;
    logic [4:0] g;
    if (!rst_n) begin
      m_idx = 0; m_grp = 5'b11111; m_line = 1'b0; m_prev = 1'b0;
      m_hist = '0; m_started = 1'b0;
      e_valid = 0; e_ctrl = 0; e_inv = 0; e_data = '0;
    end else begin
      lin = direct ? drv_line : (m_line ^ inv);
      b = (lin !== m_prev);
      m_prev = lin;
      g = {m_hist, b};
      m_hist = g[3:0];
      e_valid = rx_align; e_ctrl = 0; e_inv = 0; e_data = '0;
      if (rx_align) begin
        e_inv = 1;
        if (g == 5'b11111) begin e_ctrl = 1; e_inv = 0; e_data = 0; end
        else if (g == 5'b00000) begin e_ctrl = 1; e_inv = 0; e_data = 1; end
        else if (g == 5'b00100) begin e_ctrl = 1; e_inv = 0; e_data = 2; end
        else for (int k = 0; k < 16; k++)
          if (CODES[k] == g) begin e_inv = 0; e_data = 4'(k); end
      end
      m_line = m_line ^ m_grp[4 - m_idx];
      if (m_idx == 4) begin
        m_idx = 0;
        m_grp = tx_valid ? ref_code(tx_ctrl, tx_data) : 5'b11111;
        m_started = 1'b1;
      end else m_idx++;
    end
  end

  always @(negedge clk) loop_align = (m_idx == 0) && m_started;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking) begin
    string rt;
    chk(cur_tag, "line_out", int'(line_out), int'(m_line));
    chk(cur_tag, "tx_ready", int'(tx_ready), int'(m_idx == 4));
    if (!e_valid) rt = "R13";
    else if (e_inv) rt = "R11";
    else if (e_ctrl) rt = "R10";
    else if (direct) rt = "R7";
    else if (inv) rt = "R12";
    else rt = "R9";
    chk(e_valid ? "R8" : rt, "rx_valid", int'(rx_valid), int'(e_valid));
    chk(rt, "rx_ctrl", int'(rx_ctrl), int'(e_ctrl));
    chk(rt, "rx_data", int'(rx_data), int'(e_data));
    chk(rt, "rx_invalid", int'(rx_invalid), int'(e_inv));
  end

  task automatic send(input logic c, input logic [3:0] d);
    @(negedge clk);
    while (m_idx != 4) @(negedge clk);
    tx_valid = 1'b1; tx_ctrl = c; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0; tx_ctrl = 1'b0; tx_data = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checking = 1'b1;
    repeat (6) @(negedge clk);          // R6: reset state and first idle group
    cur_tag = "R1";
    for (int n = 0; n < 16; n++) send(1'b0, 4'(n));
    cur_tag = "R2";                     // upper selector bits set: must not matter
    for (int c = 0; c < 4; c++) send(1'b1, {2'b11, 2'(c)});
    for (int c = 0; c < 4; c++) send(1'b1, {2'b00, 2'(c)});
    cur_tag = "R5";
    repeat (25) @(negedge clk);
    cur_tag = "R12";
    inv = 1'b1;
    for (int n = 15; n >= 0; n--) send(1'b0, 4'(n));
    send(1'b1, 4'd1);
    send(1'b1, 4'd2);
    repeat (12) @(negedge clk);
    cur_tag = "R7";
    @(negedge clk);
    direct = 1'b1;
    drv_line = 1'b1;
    for (int g = 0; g < 32; g++) begin
      for (int b = 4; b >= 0; b--) begin
        drv_line = drv_line ^ g[b];
        dir_align = (b == 0);
        @(negedge clk);
      end
    end
    dir_align = 1'b0;
    repeat (4) @(negedge clk);
    checking = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule